// File: doc/BRIEF.md
# Time-Slotted Serial Transmitter

This block is the transmit side of a synchronous serial port. Parallel words are written into a small transmit queue. At the right moment each word moves into a shift register and goes out on one serial data line, most significant bit first. A bit-clock strobe times every bit, and a frame-sync input marks frame starts. The strobe is a one-cycle pulse that marks each rising bit-clock edge. The serial line is presented as a data bit plus an output enable, so the pad outside the block floats whenever no word is being shifted.

There are three operating modes. In single-word mode each frame sync launches one word. In slotted mode a frame is split into up to 32 back-to-back slots, and a mask chooses which slots carry data. In strobe-free mode no frame sync is used: words leave as soon as the queue holds data, and a gate output marks the bit periods in which the bit clock should run. Clock division, pin multiplexing and register decode are handled outside this block.

Top module: `ser_slot_tx`

## Requirements
- R1: The word length is selected by `wlen_sel`: 0 gives 8 bits, 1 gives 10, 2 gives 12 and 3 gives 16. The low bits of the queued word are sent most significant bit first. `sd_out` and `sd_oe` change only on clock edges where `bit_tick` is high.
- R2: With `fs_early`=0, a frame starts on the tick where `fsync` is first seen high. The first data bit is on `sd_out` right after that tick.
- R3: With `fs_early`=1, the first data bit appears one tick later than in R2, after the tick that follows the one where `fsync` is first seen high.
- R4: Only a low-to-high change of `fsync` between two successive ticks starts a frame. A sync held high for a whole word therefore behaves exactly like a one-tick sync.
- R5: `sd_oe` is high only during the ticks that carry the bits of a word. It is low at the tick after the last bit and whenever the block is idle.
- R6: In slotted mode (`mode`=1), slots 0 to `slot_last` follow one another, each one word long, starting at the frame start. Slot i is driven only if `slot_mask[i]` is 1. A masked slot keeps `sd_oe` low and takes no word from the queue.
- R7: In strobe-free mode (`mode`=2), `fsync` is ignored. A word starts at the first tick on which the block is idle, or is finishing a word, and the queue is not empty. Words run back to back. `gclk_en` is high exactly while a word is being shifted.
- R8: The queue holds 8 words in write order. `fifo_full` and `fifo_empty` report its state. A write while the queue is full is dropped.
- R9: In modes 0 and 1, a word that is due while the queue is empty sets `underrun`. That word's bit periods pass with `sd_oe` low. `underrun` stays set until the port is disabled.
- R10: While `port_en` is 0, `sd_oe` is low, the queue is empty, `underrun` is clear, and writes and ticks are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| port_en | input | 1 | Port enable; 0 clears the queue and the flags |
| mode | input | 2 | 0 single-word, 1 slotted, 2 strobe-free (3 acts as 0) |
| wlen_sel | input | 2 | Word length select (8/10/12/16) |
| fs_early | input | 1 | 1: frame sync leads the first bit by one bit period |
| slot_last | input | 5 | Index of the last slot in a slotted frame |
| slot_mask | input | 32 | Per-slot drive enable for slotted mode |
| wr_valid | input | 1 | Queue write strobe |
| wr_data | input | 16 | Word to queue (low bits used) |
| bit_tick | input | 1 | One-cycle pulse per rising bit-clock edge |
| fsync | input | 1 | Frame sync, sampled on ticks |
| fifo_full | output | 1 | Queue holds 8 words |
| fifo_empty | output | 1 | Queue holds no word |
| underrun | output | 1 | Sticky flag: a word was due with the queue empty |
| sd_out | output | 1 | Serial data bit |
| sd_oe | output | 1 | Serial data drive enable |
| gclk_en | output | 1 | Bit-clock gate for strobe-free mode |

## Verification
A wrong bit counter shows up directly at the ports. It either cuts a word short, with `sd_oe` dropping early, or lets the enable run into the tick after the last bit. Both are visible within one word of the fault. A slot index that is off by one drives data into a masked slot or leaves an enabled slot floating, so the error appears within the same frame. Because masked slots take nothing from the queue, it also shifts every later word. Queue pointer errors appear as words out of order, a lost word, or a premature underrun at the next frame that takes data.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

  localparam logic [1:0] TXM_NORMAL  = 2'd0;
  localparam logic [1:0] TXM_NETWORK = 2'd1;
  localparam logic [1:0] TXM_GATED   = 2'd2;

  function automatic logic [4:0] wlen_bits(input logic [1:0] sel);
    case (sel)
      2'd0:    wlen_bits = 5'd8;
      2'd1:    wlen_bits = 5'd10;
      2'd2:    wlen_bits = 5'd12;
      default: wlen_bits = 5'd16;
    endcase
  endfunction

endpackage

// File: rtl/ser_tx_fifo.sv
module ser_tx_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          full,
  output logic          empty
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW:0]   wptr_q, rptr_q;
  logic          wr_ok, rd_ok;

  assign empty   = (wptr_q == rptr_q);
  assign full    = (wptr_q[AW] != rptr_q[AW]) && (wptr_q[AW-1:0] == rptr_q[AW-1:0]);
  assign wr_ok   = wr_en && !full;
  assign rd_ok   = rd_en && !empty;
  assign rd_data = mem_q[rptr_q[AW-1:0]];

  always_ff @(posedge clk) begin
    if (wr_ok) mem_q[wptr_q[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      if (wr_ok) wptr_q <= wptr_q + 1'b1;
      if (rd_ok) rptr_q <= rptr_q + 1'b1;
    end
  end

  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (rst) rd_en |-> !empty); // R8
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst) (full && !rd_en && !clr) |=> full); // R8

endmodule

// File: rtl/ser_tx_frame.sv
module ser_tx_frame
  import ser_tx_pkg::*;
#(
  parameter int SLOTS = 32,
  parameter int SW    = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             tick,
  input  logic             fsync,
  input  logic [1:0]       mode,
  input  logic             fs_early,
  input  logic [SW-1:0]    slot_last,
  input  logic [SLOTS-1:0] slot_mask,
  input  logic             word_end,
  input  logic             busy,
  input  logic             fifo_empty,
  output logic             load,
  output logic             drive,
  output logic             pop,
  output logic             underrun_set
);
  logic          fs_prev_q, pend_q, in_frame_q;
  logic [SW-1:0] slot_q;
  logic          fs_rise, start_now, is_net, is_gated, next_ok;
  logic          begin_w, want;
  logic [SW-1:0] new_slot;

  assign fs_rise   = fsync && !fs_prev_q;
  assign start_now = fs_early ? pend_q : fs_rise;
  assign is_net    = (mode == TXM_NETWORK);
  assign is_gated  = (mode == TXM_GATED);
  assign next_ok   = in_frame_q && word_end && (slot_q != slot_last);

  always_comb begin
    begin_w  = 1'b0;
    new_slot = slot_q;
    want     = 1'b1;
    if (is_gated) begin
      begin_w = (!busy || word_end) && !fifo_empty;
    end else if (is_net) begin
      if (start_now) begin
        begin_w  = 1'b1;
        new_slot = '0;
      end else if (next_ok) begin
        begin_w  = 1'b1;
        new_slot = slot_q + SW'(1);
      end
      want = slot_mask[new_slot];
    end else begin
      begin_w = start_now;
    end
  end

  assign load         = tick && begin_w;
  assign drive        = want && !fifo_empty;
  assign pop          = load && drive;
  assign underrun_set = load && want && fifo_empty && !is_gated;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      fs_prev_q  <= 1'b0;
      pend_q     <= 1'b0;
      in_frame_q <= 1'b0;
      slot_q     <= '0;
    end else if (tick) begin
      fs_prev_q <= fsync;
      pend_q    <= fs_rise && fs_early && !is_gated;
      if (load && is_net) begin
        slot_q     <= new_slot;
        in_frame_q <= 1'b1;
      end else if (word_end) begin
        in_frame_q <= 1'b0;
      end
    end
  end

  AST_SLOT_IN_FRAME: assert property (@(posedge clk) disable iff (rst) (in_frame_q && $stable(slot_last)) |-> slot_q <= slot_last); // R6
  AST_MASKED_NO_POP: assert property (@(posedge clk) disable iff (rst) (load && is_net && !slot_mask[new_slot]) |-> !pop); // R6

endmodule

// File: rtl/ser_tx_shift.sv
module ser_tx_shift #(
  parameter int DW = 16,
  parameter int CW = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          tick,
  input  logic          load,
  input  logic          drive,
  input  logic [CW-1:0] wlen,
  input  logic [DW-1:0] din,
  output logic          sd_out,
  output logic          sd_oe,
  output logic          busy,
  output logic          word_end
);
  logic [DW-1:0] shift_q;
  logic [CW-1:0] left_q;
  logic          busy_q, oe_q;

  assign word_end = busy_q && (left_q == CW'(1));
  assign sd_out   = shift_q[DW-1];
  assign sd_oe    = oe_q;
  assign busy     = busy_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      shift_q <= '0;
      left_q  <= '0;
      busy_q  <= 1'b0;
      oe_q    <= 1'b0;
    end else if (tick) begin
      if (load) begin
        busy_q <= 1'b1;
        left_q <= wlen;
        oe_q   <= drive;
        if (drive) shift_q <= din << (CW'(DW) - wlen);
      end else if (busy_q) begin
        if (word_end) begin
          busy_q <= 1'b0;
          oe_q   <= 1'b0;
        end else begin
          left_q  <= left_q - CW'(1);
          shift_q <= shift_q << 1;
        end
      end
    end
  end

  AST_OE_NEEDS_WORD: assert property (@(posedge clk) disable iff (rst) oe_q |-> busy_q); // R5
  AST_COUNT_LIVE: assert property (@(posedge clk) disable iff (rst) busy_q |-> (left_q != '0)); // R1

endmodule

// File: rtl/ser_slot_tx.sv
module ser_slot_tx
  import ser_tx_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  parameter int SLOTS = 32,
  parameter int SW    = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             port_en,
  input  logic [1:0]       mode,
  input  logic [1:0]       wlen_sel,
  input  logic             fs_early,
  input  logic [SW-1:0]    slot_last,
  input  logic [SLOTS-1:0] slot_mask,
  input  logic             wr_valid,
  input  logic [DW-1:0]    wr_data,
  input  logic             bit_tick,
  input  logic             fsync,
  output logic             fifo_full,
  output logic             fifo_empty,
  output logic             underrun,
  output logic             sd_out,
  output logic             sd_oe,
  output logic             gclk_en
);
  localparam int CW = $clog2(DW + 1);

  logic          clr, tick, wr_en;
  logic [DW-1:0] head;
  logic          load, drive, pop, underrun_set;
  logic          busy, word_end;
  logic          underrun_q;

  assign clr   = !port_en;
  assign tick  = bit_tick && port_en;
  assign wr_en = wr_valid && port_en;

  ser_tx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .clr(clr),
    .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(pop), .rd_data(head),
    .full(fifo_full), .empty(fifo_empty)
  );

  ser_tx_frame #(.SLOTS(SLOTS), .SW(SW)) u_frame (
    .clk(clk), .rst(rst), .clr(clr), .tick(tick),
    .fsync(fsync), .mode(mode), .fs_early(fs_early),
    .slot_last(slot_last), .slot_mask(slot_mask),
    .word_end(word_end), .busy(busy), .fifo_empty(fifo_empty),
    .load(load), .drive(drive), .pop(pop), .underrun_set(underrun_set)
  );

  ser_tx_shift #(.DW(DW), .CW(CW)) u_shift (
    .clk(clk), .rst(rst), .clr(clr), .tick(tick),
    .load(load), .drive(drive), .wlen(CW'(wlen_bits(wlen_sel))),
    .din(head),
    .sd_out(sd_out), .sd_oe(sd_oe), .busy(busy), .word_end(word_end)
  );

  always_ff @(posedge clk) begin
    if (rst || clr)        underrun_q <= 1'b0;
    else if (underrun_set) underrun_q <= 1'b1;
  end

  assign underrun = underrun_q;
  assign gclk_en  = busy && (mode == TXM_GATED);

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst) !port_en |=> (!sd_oe && fifo_empty && !underrun)); // R10
  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (rst) (port_en && underrun) |=> underrun); // R9
  AST_HOLD_OFF_TICK: assert property (@(posedge clk) disable iff (rst) (port_en && !bit_tick) |=> ($stable(sd_out) && $stable(sd_oe))); // R1
  AST_GATE_HAS_DATA: assert property (@(posedge clk) disable iff (rst) (gclk_en && $stable(mode)) |-> sd_oe); // R7

endmodule

// File: tb/ser_slot_tx_bench.sv
module ser_slot_tx_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        port_en = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [1:0]  wlen_sel = 2'd0;
  logic        fs_early = 1'b0;
  logic [4:0]  slot_last = 5'd0;
  logic [31:0] slot_mask = 32'd0;
  logic        wr_valid = 1'b0;
  logic [15:0] wr_data = 16'd0;
  logic        bit_tick = 1'b0;
  logic        fsync = 1'b0;
  logic        fifo_full, fifo_empty, underrun, sd_out, sd_oe, gclk_en;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  ser_slot_tx u_ser_slot_tx (
    .clk(clk), .rst(rst), .port_en(port_en), .mode(mode), .wlen_sel(wlen_sel),
    .fs_early(fs_early), .slot_last(slot_last), .slot_mask(slot_mask),
    .wr_valid(wr_valid), .wr_data(wr_data), .bit_tick(bit_tick), .fsync(fsync),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty), .underrun(underrun),
    .sd_out(sd_out), .sd_oe(sd_oe), .gclk_en(gclk_en)
  );

  function automatic int blen(input logic [1:0] sel);
    case (sel)
      2'd0: return 8;
      2'd1: return 10;
      2'd2: return 12;
      default: return 16;
    endcase
  endfunction

  function automatic logic [15:0] lowbits(input logic [15:0] w, input int len);
    return w & 16'((32'd1 << len) - 1);
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic push(input logic [15:0] d);
    wr_valid = 1'b1;
    wr_data  = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic do_tick(input logic fs, output logic o, output logic e, output logic g);
    bit_tick = 1'b1;
    fsync    = fs;
    @(negedge clk);
    o = sd_out; e = sd_oe; g = gclk_en;
    bit_tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_bits(input int len, input int fslen, output logic [15:0] got,
                          output logic all_oe, output logic any_oe, output logic all_g);
    logic o, e, g;
    got = '0; all_oe = 1'b1; any_oe = 1'b0; all_g = 1'b1;
    for (int i = 0; i < len; i++) begin
      do_tick(i < fslen, o, e, g);
      got = {got[14:0], o};
      all_oe &= e; any_oe |= e; all_g &= g;
    end
  endtask

  task automatic send_word(input int len, input logic [15:0] w, input logic early,
                           input int fslen, input string tag);
    logic [15:0] got;
    logic all_oe, any_oe, all_g, o, e, g;
    if (early) begin
      do_tick(1'b1, o, e, g);
      check({tag, " early lead tick floats"}, e, 0);
      run_bits(len, fslen - 1, got, all_oe, any_oe, all_g);
    end else begin
      run_bits(len, fslen, got, all_oe, any_oe, all_g);
    end
    check({tag, " data"}, got, lowbits(w, len));
    check({tag, " R5 enable across word"}, all_oe, 1);
    do_tick(1'b0, o, e, g);
    check("R5 enable low after last bit", e, 0);
  endtask

  initial begin
    logic [15:0] got, w;
    logic all_oe, any_oe, all_g, o, e, g, acc;
    int rnd, len;
    rnd = $urandom(32'h51A7);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R10 reset oe", sd_oe, 0);
    check("R8 reset empty", fifo_empty, 1);
    check("R8 reset full", fifo_full, 0);
    check("R9 reset underrun", underrun, 0);
    port_en = 1'b1;
    @(negedge clk);

    // R1/R2: each word length, aligned one-bit sync
    for (int s = 0; s < 4; s++) begin
      wlen_sel = 2'(s);
      push(16'hB5C3 ^ 16'(s * 16'h1111));
      send_word(blen(2'(s)), 16'hB5C3 ^ 16'(s * 16'h1111), 1'b0, 1, "R1 R2 word length");
    end
    // R4: word-long sync, aligned and early
    wlen_sel = 2'd2;
    push(16'h0A5E);
    send_word(12, 16'h0A5E, 1'b0, 12, "R4 word-long sync aligned");
    fs_early = 1'b1;
    push(16'h0C71);
    send_word(12, 16'h0C71, 1'b1, 12, "R4 word-long sync early");
    // R3: early one-bit sync
    wlen_sel = 2'd3;
    push(16'h8001);
    send_word(16, 16'h8001, 1'b1, 1, "R3 early one-bit sync");
    fs_early = 1'b0;

    // R8: fill, drop overflow, order
    wlen_sel = 2'd0;
    for (int i = 0; i < 9; i++) push(16'(8'hA0 + i));
    check("R8 full after 8 writes", fifo_full, 1);
    for (int i = 0; i < 8; i++) send_word(8, 16'(8'hA0 + i), 1'b0, 1, "R8 order");
    check("R8 empty after drain (9th write dropped)", fifo_empty, 1);
    check("R9 no underrun yet", underrun, 0);
    // R9: frame with empty queue
    run_bits(8, 1, got, all_oe, any_oe, all_g);
    check("R9 underrun word floats", any_oe, 0);
    check("R9 underrun set", underrun, 1);
    do_tick(1'b0, o, e, g);
    push(16'h005A);
    send_word(8, 16'h005A, 1'b0, 1, "R9 later word");
    check("R9 underrun sticky", underrun, 1);
    // R10: disable clears
    push(16'h0011); push(16'h0022);
    port_en = 1'b0;
    @(negedge clk);
    check("R10 disabled empty", fifo_empty, 1);
    check("R10 disabled underrun", underrun, 0);
    push(16'h0033);
    do_tick(1'b1, o, e, g);
    check("R10 disabled tick floats", e, 0);
    port_en = 1'b1;
    @(negedge clk);
    check("R10 write while disabled ignored", fifo_empty, 1);

    // R6: slotted, 4 slots, slot 2 masked
    mode = 2'd1; wlen_sel = 2'd0; slot_last = 5'd3; slot_mask = 32'h0000_000B;
    push(16'h00C1); push(16'h00C2); push(16'h00C3);
    run_bits(8, 1, got, all_oe, any_oe, all_g);
    check("R6 slot0 data", got, 16'h00C1); check("R6 slot0 oe", all_oe, 1);
    run_bits(8, 0, got, all_oe, any_oe, all_g);
    check("R6 slot1 data", got, 16'h00C2);
    run_bits(8, 0, got, all_oe, any_oe, all_g);
    check("R6 masked slot2 floats", any_oe, 0);
    check("R6 masked slot takes nothing", fifo_empty, 0);
    run_bits(8, 0, got, all_oe, any_oe, all_g);
    check("R6 slot3 data", got, 16'h00C3); check("R6 slot3 oe", all_oe, 1);
    do_tick(1'b0, o, e, g);
    check("R6 floats after last slot", e, 0);
    check("R9 no underrun in masked slot", underrun, 0);
    // R6: 32 slots, only last enabled
    slot_last = 5'd31; slot_mask = 32'h8000_0000;
    push(16'h0096);
    acc = 1'b0;
    for (int s = 0; s < 31; s++) begin
      run_bits(8, (s == 0) ? 1 : 0, got, all_oe, any_oe, all_g);
      acc |= any_oe;
    end
    check("R6 slots 0-30 float", acc, 0);
    check("R6 word kept for slot31", fifo_empty, 0);
    run_bits(8, 0, got, all_oe, any_oe, all_g);
    check("R6 slot31 data", got, 16'h0096); check("R6 slot31 oe", all_oe, 1);
    do_tick(1'b0, o, e, g);

    // R7: strobe-free
    mode = 2'd2; wlen_sel = 2'd2;
    do_tick(1'b1, o, e, g);
    do_tick(1'b0, o, e, g);
    check("R7 sync ignored, empty queue idles", {e, g}, 0);
    push(16'h0ABC); push(16'h0123);
    run_bits(12, 0, got, all_oe, any_oe, all_g);
    check("R7 word1 data", got, 16'h0ABC); check("R7 word1 gate", {all_oe, all_g}, 2'b11);
    run_bits(12, 0, got, all_oe, any_oe, all_g);
    check("R7 word2 back to back", got, 16'h0123); check("R7 word2 gate", {all_oe, all_g}, 2'b11);
    do_tick(1'b0, o, e, g);
    check("R7 gate off when drained", {e, g}, 0);

    // random single-word frames
    mode = 2'd0;
    for (int k = 0; k < 24; k++) begin
      wlen_sel = 2'($urandom_range(0, 3));
      fs_early = 1'($urandom_range(0, 1));
      len = blen(wlen_sel);
      w = 16'($urandom);
      push(w);
      send_word(len, w, fs_early, ($urandom_range(0, 1) != 0) ? len : 1, "R1 R2 R3 R4 random");
    end
    fs_early = 1'b0;

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements) got timeout exp completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule